// File: doc/BRIEF.md
# FIFO-Level DMA Request Generator

This block turns the fill levels of a serial peripheral's transmit and receive FIFOs into transfer requests for a DMA controller. It raises two requests for each direction.

- The single request asks for one data item. On the transmit side it fires while the FIFO has a free stage. On the receive side it fires while the FIFO holds data.
- The burst request compares the fill level with a programmable threshold. The transmit burst fires at or below its threshold. The receive burst fires at or above its threshold.

A separate enable gates each direction. Each request has its own completion input from the DMA controller.

Each request is a registered handshake. The request stays high until its completion pulse arrives. It then drops for exactly one clock, so the controller sees a fresh rising edge. If the condition still holds, it rises again on the following clock.

Clearing a direction's enable withdraws that direction's pending requests on the next clock. A synchronous software reset returns every request to idle.

Top module: `dma_req_gen`

## Requirements
- R1: When `tx_dma_en` is 0 at a clock edge, both `tx_single_req` and `tx_burst_req` are 0 after that edge. This holds even for a pending request that has had no completion.
- R2: When `rx_dma_en` is 0 at a clock edge, both `rx_single_req` and `rx_burst_req` are 0 after that edge. This holds even for a pending request that has had no completion.
- R3: `tx_single_req` may only rise after an edge at which `tx_level` was below the FIFO depth of 8, that is, at least one free stage.
- R4: `tx_burst_req` may only rise after an edge at which `tx_level` <= `tx_thresh`, both compared as unsigned 4-bit values.
- R5: `rx_single_req` may only rise after an edge at which `rx_level` was at least 1.
- R6: `rx_burst_req` may only rise after an edge at which `rx_level` >= `rx_thresh`, both compared as unsigned 4-bit values.
- R7: An idle request rises on the first clock edge at which its enable is 1 and its condition holds. Once high, it stays high while its completion input is 0, its enable is 1 and `sw_rst` is 0, even if the condition goes away.
- R8: A request whose completion input is 1 at an edge is 0 for the next cycle. If its enable and condition hold at that next edge, it is 1 again one cycle later.
- R9: `sw_rst` at 1 on a clock edge clears all four requests after that edge. It takes priority over every other input.
- R10: While `rst_n` is 0, all four request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset |
| tx_dma_en | input | 1 | Transmit request enable |
| rx_dma_en | input | 1 | Receive request enable |
| tx_level | input | 4 | Transmit FIFO fill level, 0 to 8 |
| rx_level | input | 4 | Receive FIFO fill level, 0 to 8 |
| tx_thresh | input | 4 | Transmit burst threshold |
| rx_thresh | input | 4 | Receive burst threshold |
| tx_single_done | input | 1 | Completion pulse for the transmit single request |
| tx_burst_done | input | 1 | Completion pulse for the transmit burst request |
| rx_single_done | input | 1 | Completion pulse for the receive single request |
| rx_burst_done | input | 1 | Completion pulse for the receive burst request |
| tx_single_req | output | 1 | Transmit single request |
| tx_burst_req | output | 1 | Transmit burst request |
| rx_single_req | output | 1 | Receive single request |
| rx_burst_req | output | 1 | Receive burst request |

## Verification
The bench builds the block with its defaults: a depth of 8 and 4-bit levels and thresholds.

Levels are drawn across the whole legal range of 0 to 8, while thresholds take every 4-bit value. This covers three kinds of case:
- Settings where a burst condition can never hold, such as a receive threshold above 8.
- Settings where it always holds, such as a transmit threshold of 8 or more.
- The exact equality points that separate firing from silence.

Random completion pulses and enable drops exercise the hold, gap and withdrawal paths of each request. Directed sequences then pin down these cases:
- the FIFO-full and FIFO-empty edges;
- the one-cycle gap after completion;
- software-reset priority.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  localparam int NUM_CH = 4;
  localparam int CH_TXS = 0;
  localparam int CH_TXB = 1;
  localparam int CH_RXS = 2;
  localparam int CH_RXB = 3;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_REQ  = 1'b1
  } ch_state_e;

endpackage

// File: rtl/dma_req_cond.sv
module dma_req_cond
  import dma_req_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = 4
) (
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_thresh,
  input  logic [LVL_W-1:0]  rx_thresh,
  output logic [NUM_CH-1:0] cond
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);

  always_comb begin
    cond         = '0;
    // a free stage exists while the level is below the depth
    cond[CH_TXS] = (tx_level < DEPTH_L);
    cond[CH_TXB] = (tx_level <= tx_thresh);
    cond[CH_RXS] = (rx_level != '0);
    cond[CH_RXB] = (rx_level >= rx_thresh);
  end

endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan
  import dma_req_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic en,
  input  logic cond,
  input  logic done,
  output logic req
);

  ch_state_e state_q;
  ch_state_e state_d;
  logic      st_load;

  always_comb begin
    state_d = state_q;
    if (sw_rst) begin
      state_d = CH_IDLE;
    end else begin
      unique case (state_q)
        CH_IDLE: if (en && cond)   state_d = CH_REQ;
        CH_REQ:  if (!en || done)  state_d = CH_IDLE;
        default:                   state_d = CH_IDLE;
      endcase
    end
  end

  assign st_load = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
    end else if (st_load) begin
      state_q <= state_d;
    end
  end

  assign req = (state_q == CH_REQ);

endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             tx_dma_en,
  input  logic             rx_dma_en,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic             tx_single_done,
  input  logic             tx_burst_done,
  input  logic             rx_single_done,
  input  logic             rx_burst_done,
  output logic             tx_single_req,
  output logic             tx_burst_req,
  output logic             rx_single_req,
  output logic             rx_burst_req
);

  logic [NUM_CH-1:0] ch_cond;
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] ch_done;
  logic [NUM_CH-1:0] ch_req;

  dma_req_cond #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W)
  ) u_cond (
    .tx_level  (tx_level),
    .rx_level  (rx_level),
    .tx_thresh (tx_thresh),
    .rx_thresh (rx_thresh),
    .cond      (ch_cond)
  );

  always_comb begin
    ch_en           = '0;
    ch_en[CH_TXS]   = tx_dma_en;
    ch_en[CH_TXB]   = tx_dma_en;
    ch_en[CH_RXS]   = rx_dma_en;
    ch_en[CH_RXB]   = rx_dma_en;
    ch_done         = '0;
    ch_done[CH_TXS] = tx_single_done;
    ch_done[CH_TXB] = tx_burst_done;
    ch_done[CH_RXS] = rx_single_done;
    ch_done[CH_RXB] = rx_burst_done;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    dma_req_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_rst (sw_rst),
      .en     (ch_en[i]),
      .cond   (ch_cond[i]),
      .done   (ch_done[i]),
      .req    (ch_req[i])
    );
  end

  assign tx_single_req = ch_req[CH_TXS];
  assign tx_burst_req  = ch_req[CH_TXB];
  assign rx_single_req = ch_req[CH_RXS];
  assign rx_burst_req  = ch_req[CH_RXB];

endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk #(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_rst,
  input logic             tx_dma_en,
  input logic             rx_dma_en,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_thresh,
  input logic [LVL_W-1:0] rx_thresh,
  input logic             tx_single_done,
  input logic             tx_burst_done,
  input logic             rx_single_done,
  input logic             rx_burst_done,
  input logic             tx_single_req,
  input logic             tx_burst_req,
  input logic             rx_single_req,
  input logic             rx_burst_req
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);

  assert_tx_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dma_en |=> (!tx_single_req && !tx_burst_req));

  assert_rx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dma_en |=> (!rx_single_req && !rx_burst_req));

  assert_tx_single_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_single_req) |-> $past(tx_level < DEPTH_L));

  assert_tx_burst_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_burst_req) |-> $past(tx_level <= tx_thresh));

  assert_rx_single_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_single_req) |-> $past(rx_level != '0));

  assert_rx_burst_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_burst_req) |-> $past(rx_level >= rx_thresh));

  assert_tx_burst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_burst_req && !tx_burst_done && tx_dma_en && !sw_rst) |=> tx_burst_req);

  assert_rx_single_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_single_req && !rx_single_done && rx_dma_en && !sw_rst) |=> rx_single_req);

  assert_tx_single_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_single_req && tx_single_done) |=> !tx_single_req);

  assert_rx_burst_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_burst_req && rx_burst_done) |=> !rx_burst_req);

  assert_sw_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !(tx_single_req || tx_burst_req || rx_single_req || rx_burst_req));

  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R10: assert (!(tx_single_req || tx_burst_req ||
                                       rx_single_req || rx_burst_req));
    end
  end

endmodule

bind dma_req_gen dma_req_gen_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .LVL_W      (LVL_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sw_rst         (sw_rst),
  .tx_dma_en      (tx_dma_en),
  .rx_dma_en      (rx_dma_en),
  .tx_level       (tx_level),
  .rx_level       (rx_level),
  .tx_thresh      (tx_thresh),
  .rx_thresh      (rx_thresh),
  .tx_single_done (tx_single_done),
  .tx_burst_done  (tx_burst_done),
  .rx_single_done (rx_single_done),
  .rx_burst_done  (rx_burst_done),
  .tx_single_req  (tx_single_req),
  .tx_burst_req   (tx_burst_req),
  .rx_single_req  (rx_single_req),
  .rx_burst_req   (rx_burst_req)
);

// File: tb/dma_req_gen_test.sv
`timescale 1ns/1ps
module dma_req_gen_test;

  localparam int DEPTH = 8;
  localparam int LW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sw_rst;
  logic          tx_dma_en, rx_dma_en;
  logic [LW-1:0] tx_level, rx_level, tx_thresh, rx_thresh;
  logic          tx_single_done, tx_burst_done, rx_single_done, rx_burst_done;
  logic          tx_single_req, tx_burst_req, rx_single_req, rx_burst_req;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  logic [3:0] mdl = '0;   // 0 tx single, 1 tx burst, 2 rx single, 3 rx burst

  always #4 clk = ~clk;   // 125 MHz

  dma_req_gen #(.FIFO_DEPTH(DEPTH), .LVL_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .tx_single_done(tx_single_done), .tx_burst_done(tx_burst_done),
    .rx_single_done(rx_single_done), .rx_burst_done(rx_burst_done),
    .tx_single_req(tx_single_req), .tx_burst_req(tx_burst_req),
    .rx_single_req(rx_single_req), .rx_burst_req(rx_burst_req)
  );

  function automatic logic [3:0] conds();
    logic [3:0] c;
    c[0] = (int'(tx_level) < DEPTH);        // R3
    c[1] = (tx_level <= tx_thresh);         // R4
    c[2] = (rx_level != 0);                 // R5
    c[3] = (rx_level >= rx_thresh);         // R6
    return c;
  endfunction

  function automatic logic [3:0] predict(logic [3:0] cur);
    logic [3:0] c, en, dn, nx;
    c  = conds();
    en = {rx_dma_en, rx_dma_en, tx_dma_en, tx_dma_en};
    dn = {rx_burst_done, rx_single_done, tx_burst_done, tx_single_done};
    for (int i = 0; i < 4; i++) begin
      if (sw_rst)      nx[i] = 1'b0;                  // R9
      else if (cur[i]) nx[i] = en[i] && !dn[i];       // R1 R2 R7 R8
      else             nx[i] = en[i] && c[i];         // R7
    end
    return nx;
  endfunction

  function automatic logic [3:0] outs();
    return {rx_burst_req, rx_single_req, tx_burst_req, tx_single_req};
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [3:0] nx;
    string tags [4];
    string nm [4];
    tags = '{"R3", "R4", "R5", "R6"};
    nm   = '{"tx_single", "tx_burst", "rx_single", "rx_burst"};
    nx = rst_n ? predict(mdl) : 4'b0;
    @(posedge clk);
    #1;
    mdl = nx;
    for (int i = 0; i < 4; i++) check(tags[i], outs()[i], mdl[i], nm[i]);
  endtask

  task automatic idle_inputs();
    sw_rst = 0; tx_dma_en = 0; rx_dma_en = 0;
    tx_level = 0; rx_level = 0; tx_thresh = 0; rx_thresh = 0;
    tx_single_done = 0; tx_burst_done = 0; rx_single_done = 0; rx_burst_done = 0;
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'd20240611);
    idle_inputs();
    rst_n = 0;
    tx_dma_en = 1; rx_dma_en = 1; rx_level = 5; tx_thresh = 8;
    @(posedge clk); #1;
    check("R10", |outs(), 1'b0, "all requests in reset");
    @(posedge clk); #1;
    check("R10", |outs(), 1'b0, "all requests held in reset");
    rst_n = 1;
    idle_inputs();
    tick();

    // R3 boundary: full FIFO gives no single request, seven gives one
    tx_dma_en = 1; tx_level = 8; tx_thresh = 0;
    tick();
    check("R3", tx_single_req, 1'b0, "tx single at level 8");
    tx_level = 7;
    tick();
    check("R3", tx_single_req, 1'b1, "tx single at level 7");

    // R4 boundary: level equal to threshold fires, one above does not
    tx_thresh = 4'd6;
    tick();
    check("R4", tx_burst_req, 1'b0, "tx burst level 7 thresh 6");
    tx_level = 6;
    tick();
    check("R4", tx_burst_req, 1'b1, "tx burst level 6 thresh 6");

    // R7: the request holds after the condition disappears
    tx_level = 8;
    tick();
    check("R7", tx_burst_req, 1'b1, "tx burst held without completion");
    check("R7", tx_single_req, 1'b1, "tx single held without completion");

    // R8: completion gives a one-cycle gap, then the request rises again
    tx_level = 2; tx_burst_done = 1;
    tick();
    check("R8", tx_burst_req, 1'b0, "tx burst gap after completion");
    tx_burst_done = 0;
    tick();
    check("R8", tx_burst_req, 1'b1, "tx burst re-raised while level <= thresh");

    // R1: withdrawal without completion
    tx_dma_en = 0;
    tick();
    check("R1", tx_single_req | tx_burst_req, 1'b0, "tx requests after enable cleared");

    // R5 / R6 boundaries
    rx_dma_en = 1; rx_level = 0; rx_thresh = 4'd3;
    tick();
    check("R5", rx_single_req, 1'b0, "rx single at empty");
    rx_level = 2;
    tick();
    check("R5", rx_single_req, 1'b1, "rx single at level 2");
    check("R6", rx_burst_req, 1'b0, "rx burst level 2 thresh 3");
    rx_level = 3;
    tick();
    check("R6", rx_burst_req, 1'b1, "rx burst level 3 thresh 3");

    // R2: withdrawal without completion
    rx_dma_en = 0;
    tick();
    check("R2", rx_single_req | rx_burst_req, 1'b0, "rx requests after enable cleared");

    // R9: software reset wins over an active condition
    rx_dma_en = 1; tx_dma_en = 1; tx_level = 0; tx_thresh = 4;
    tick();
    sw_rst = 1;
    tick();
    check("R9", |outs(), 1'b0, "all requests after software reset");
    sw_rst = 0;
    tick();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      tx_level       = LW'($urandom_range(0, DEPTH));
      rx_level       = LW'($urandom_range(0, DEPTH));
      tx_thresh      = LW'($urandom_range(0, 15));
      rx_thresh      = LW'($urandom_range(0, 15));
      tx_dma_en      = ($urandom_range(0, 9) != 0);
      rx_dma_en      = ($urandom_range(0, 9) != 0);
      tx_single_done = ($urandom_range(0, 3) == 0);
      tx_burst_done  = ($urandom_range(0, 3) == 0);
      rx_single_done = ($urandom_range(0, 3) == 0);
      rx_burst_done  = ($urandom_range(0, 3) == 0);
      sw_rst         = ($urandom_range(0, 99) == 0);
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule